// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only configuration port driven by an external controller over three slow wires: a control clock, a data line and a latch line. Every rising edge of the control clock pushes one data bit into a shift register, most significant bit first. A rising edge on the latch line commits the word that has been assembled. All three wires are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are found in the system clock domain.

A word is 10 bits long. The top two bits pick the destination: the left gain value, the right gain value, or a configuration byte. The configuration byte holds a 4-bit output routing code, a de-emphasis enable and a shared-gain flag. While the shared-gain flag is set, the left gain value drives both channel outputs. A small state machine counts the bits that arrive between latch edges. Its states are `ST_EMPTY` (no bits since the last latch), `ST_FILLING` (1 to 9 bits) and `ST_FULL` (10 or more bits). It moves from `ST_EMPTY` to `ST_FILLING` on the first bit and from `ST_FILLING` to `ST_FULL` on the tenth bit. Every latch edge returns it to `ST_EMPTY`, and a word is committed only when that latch edge is seen with the count at ten.

Top module: `sctl_port`

## Requirements
- R1: After reset, both gain outputs read 255, the routing code reads 4'h9, and de-emphasis and shared gain both read 0.
- R2: One data bit is taken on each synchronized rising edge of the control clock. The word is assembled MSB first, and bits [9:8] are the select field.
- R3: The outputs change only after a latch rising edge. Control clock edges and data changes alone leave them unchanged.
- R4: Select 2'b00 loads bits [7:0] into the left gain. Select 2'b01 loads bits [7:0] into the right gain.
- R5: Select 2'b10 loads bits [3:0] into the routing code, bit 4 into de-emphasis (1 = on) and bit 5 into the shared-gain flag. Bits [7:6] are ignored.
- R6: While shared gain is 1, the right gain output equals the left gain. The stored right value is kept and reappears when the flag is cleared.
- R7: A word with select 2'b11 changes no output.
- R8: A latch edge that follows fewer than 10 bits since the previous latch edge (or since reset) is discarded. Every latch edge restarts the bit count.
- R9: When more than 10 bits arrive before a latch edge, the last 10 bits form the word.
- R10: When a control clock rise and a latch rise reach the system domain in the same cycle, the bit is shifted in first and the latch sees the word that includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_clk_i | input | 1 | Asynchronous serial control clock |
| ctl_dat_i | input | 1 | Asynchronous serial data |
| ctl_lat_i | input | 1 | Asynchronous latch line; the rising edge commits the word |
| gain_l_o | output | 8 | Left channel gain value |
| gain_r_o | output | 8 | Effective right channel gain value (the left value while shared gain is set) |
| route_o | output | 4 | Output routing code |
| deemph_o | output | 1 | De-emphasis enable |
| shared_o | output | 1 | Shared-gain flag |

## Verification
The bit shift and the word commit can land in the same system cycle when the control clock and the latch line rise together. The bench sends nine bits, then raises the tenth control clock edge and the latch line at the same instant. It expects the commit to use the ten-bit word that includes the last bit; a commit that missed it would be discarded as too short. Constrained random words of 6 to 13 bits, with every select value, are compared with a bench model that keeps the last ten bits and discards short words.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int WORD_W  = 10;
    localparam int SEL_W   = 2;
    localparam int DATA_W  = WORD_W - SEL_W;
    localparam int ROUTE_W = 4;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    localparam logic [DATA_W-1:0]  GAIN_RST  = '1;
    localparam logic [ROUTE_W-1:0] ROUTE_RST = 4'h9;

    typedef enum logic [SEL_W-1:0] {
        SEL_LEFT  = 2'b00,
        SEL_RIGHT = 2'b01,
        SEL_CFG   = 2'b10,
        SEL_NONE  = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_FULL    = 2'd2
    } fill_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= async_i[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign level_o[i] = s2;
        assign rise_o[i]  = s2 & ~s3;
    end
endmodule

// File: rtl/sctl_shift_fsm.sv
module sctl_shift_fsm
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              dat,
    input  logic              lat_rise,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o,
    output fill_e             state_o
);
    fill_e             state_q, state_n;
    logic [WORD_W-1:0] sh_q, sh_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_shift;
    logic              commit_n;

    // next-state and datapath decisions
    always_comb begin
        sh_n      = bit_rise ? {sh_q[WORD_W-2:0], dat} : sh_q;
        cnt_shift = (bit_rise && cnt_q < CNT_W'(WORD_W)) ? cnt_q + 1'b1 : cnt_q;
        commit_n  = 1'b0;
        state_n   = state_q;
        cnt_n     = cnt_shift;
        if (lat_rise) begin
            commit_n = (cnt_shift == CNT_W'(WORD_W));
            cnt_n    = '0;
            state_n  = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY:   if (cnt_shift != '0) state_n = ST_FILLING;
                ST_FILLING: if (cnt_shift == CNT_W'(WORD_W)) state_n = ST_FULL;
                ST_FULL:    state_n = ST_FULL;
                default:    state_n = ST_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            commit_o <= 1'b0;
            word_o   <= '0;
        end else begin
            sh_q     <= sh_n;
            cnt_q    <= cnt_n;
            commit_o <= commit_n;
            if (commit_n) word_o <= sh_n;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [WORD_W-1:0]  word,
    output logic [DATA_W-1:0]  gain_l_o,
    output logic [DATA_W-1:0]  gain_r_o,
    output logic [ROUTE_W-1:0] route_o,
    output logic               deemph_o,
    output logic               shared_o
);
    sel_e              sel;
    logic [DATA_W-1:0] payload;
    logic [DATA_W-1:0] left_q, right_q;
    logic              unused_rsvd;

    assign sel         = sel_e'(word[WORD_W-1 -: SEL_W]);
    assign payload     = word[DATA_W-1:0];
    assign unused_rsvd = ^payload[DATA_W-1:6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q   <= GAIN_RST;
            right_q  <= GAIN_RST;
            route_o  <= ROUTE_RST;
            deemph_o <= 1'b0;
            shared_o <= 1'b0;
        end else if (commit) begin
            unique case (sel)
                SEL_LEFT:  left_q  <= payload;
                SEL_RIGHT: right_q <= payload;
                SEL_CFG: begin
                    route_o  <= payload[ROUTE_W-1:0];
                    deemph_o <= payload[4];
                    shared_o <= payload[5];
                end
                SEL_NONE:  ;
                default:   ;
            endcase
        end
    end

    assign gain_l_o = left_q;
    assign gain_r_o = shared_o ? left_q : right_q;
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_clk_i,
    input  logic         ctl_dat_i,
    input  logic         ctl_lat_i,
    output logic [7:0]   gain_l_o,
    output logic [7:0]   gain_r_o,
    output logic [3:0]   route_o,
    output logic         deemph_o,
    output logic         shared_o
);
    logic [2:0]        lvl, rise;
    logic              commit;
    logic [WORD_W-1:0] word;
    fill_e             fill_state;
    logic              unused_edges;

    assign unused_edges = ^{lvl[0], lvl[2], rise[1]};

    sctl_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ctl_lat_i, ctl_dat_i, ctl_clk_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    sctl_shift_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (rise[0]),
        .dat      (lvl[1]),
        .lat_rise (rise[2]),
        .commit_o (commit),
        .word_o   (word),
        .state_o  (fill_state)
    );

    sctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .word     (word),
        .gain_l_o (gain_l_o),
        .gain_r_o (gain_r_o),
        .route_o  (route_o),
        .deemph_o (deemph_o),
        .shared_o (shared_o)
    );
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk
    import sctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        lat_rise,
    input logic        bit_rise,
    input logic        commit,
    input logic [9:0]  word,
    input fill_e       fill_state,
    input logic [7:0]  gain_l,
    input logic [7:0]  gain_r,
    input logic [3:0]  route,
    input logic        deemph,
    input logic        shared
);
    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gain_l == 8'hFF && gain_r == 8'hFF && route == 4'h9
                          && !deemph && !shared));

    a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(gain_l) && $stable(gain_r) && $stable(route)
                     && $stable(deemph) && $stable(shared)));

    a_r8_short_word_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_rise && !bit_rise && fill_state != ST_FULL) |=> !commit);

    a_r8_latch_empties: assert property (@(posedge clk) disable iff (!rst_n)
        lat_rise |=> fill_state == ST_EMPTY);

    a_r7_select_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[9:8] == 2'b11) |=> ($stable(gain_l) && $stable(gain_r)
                     && $stable(route) && $stable(deemph) && $stable(shared)));

    a_r6_shared_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[9:8] == 2'b10 && word[5]) |=> gain_r == gain_l);
endmodule

bind sctl_port sctl_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_rise   (rise[2]),
    .bit_rise   (rise[0]),
    .commit     (commit),
    .word       (word),
    .fill_state (fill_state),
    .gain_l     (gain_l_o),
    .gain_r     (gain_r_o),
    .route      (route_o),
    .deemph     (deemph_o),
    .shared     (shared_o)
);

// File: tb/sctl_port_tb.sv
`timescale 1ns/1ps
module sctl_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_clk = 1'b0, ctl_dat = 1'b0, ctl_lat = 1'b0;
    logic [7:0] gain_l, gain_r;
    logic [3:0] route;
    logic deemph, shared;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_l = 8'hFF, m_r = 8'hFF;
    logic [3:0] m_route = 4'h9;
    logic m_dem = 1'b0, m_sh = 1'b0;
    logic [9:0] m_shift = '0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    sctl_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_clk_i(ctl_clk), .ctl_dat_i(ctl_dat), .ctl_lat_i(ctl_lat),
        .gain_l_o(gain_l), .gain_r_o(gain_r), .route_o(route),
        .deemph_o(deemph), .shared_o(shared)
    );

    function automatic logic [7:0] exp_right();
        return m_sh ? m_l : m_r;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "gain_l", gain_l, m_l);
        chk(req, "gain_r", gain_r, exp_right());
        chk(req, "route", route, m_route);
        chk(req, "deemph", deemph, m_dem);
        chk(req, "shared", shared, m_sh);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ctl_dat = b;
        wait_n(4); ctl_clk = 1'b1;
        wait_n(4); ctl_clk = 1'b0;
        wait_n(2);
        m_shift = {m_shift[8:0], b};
        m_cnt++;
    endtask

    task automatic model_latch();
        if (m_cnt >= 10) begin
            case (m_shift[9:8])
                2'b00: m_l = m_shift[7:0];
                2'b01: m_r = m_shift[7:0];
                2'b10: begin
                    m_route = m_shift[3:0];
                    m_dem   = m_shift[4];
                    m_sh    = m_shift[5];
                end
                default: ;
            endcase
        end
        m_cnt = 0;
    endtask

    task automatic latch();
        @(negedge clk); ctl_lat = 1'b1;
        wait_n(4); ctl_lat = 1'b0;
        wait_n(8);
        model_latch();
    endtask

    // sends the low n bits of w, MSB of that range first
    task automatic send_word(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    initial begin
        void'($urandom(32'd5150));
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        chk_all("R1");

        // R2/R4: left and right loads
        send_word(16'h0_0A5, 10); latch(); chk_all("R4");
        send_word(16'h1_3C, 10);  latch(); chk_all("R4");
        // R5: config word, reserved bits set
        send_word({6'd0, 2'b10, 8'b1101_0110}, 10); latch(); chk_all("R5");
        // R3: clock edges without latch change nothing
        send_word(16'h3FF, 10);
        chk_all("R3");
        latch();
        // R7: select 11 ignored
        send_word({6'd0, 2'b11, 8'h00}, 10); latch(); chk_all("R7");
        // R6: shared gain on, then off
        send_word({6'd0, 2'b10, 8'b0010_1001}, 10); latch(); chk_all("R6");
        chk("R6", "mirror", gain_r, gain_l);
        send_word({6'd0, 2'b01, 8'h11}, 10); latch(); chk_all("R6");
        send_word({6'd0, 2'b10, 8'b0000_1001}, 10); latch(); chk_all("R6");
        chk("R6", "right restored", gain_r, 8'h11);
        // R8: short word dropped
        send_word({7'd0, 1'b0, 8'h77}, 9); latch(); chk_all("R8");
        chk("R8", "left kept", gain_l, 8'hA5);
        // R8: count restarts, 5 bits then latch then 5 bits then latch
        send_word(16'h00, 5); latch();
        send_word(16'h1F, 5); latch(); chk_all("R8");
        // R9: 12 bits, last 10 used
        send_word({4'd0, 2'b11, 2'b00, 8'h42}, 12); latch(); chk_all("R9");
        chk("R9", "left from last ten", gain_l, 8'h42);

        // R10: tenth clock edge and latch rise together
        send_word({7'd0, 2'b01, 7'b1100110}, 9);
        @(negedge clk); ctl_dat = 1'b1;
        wait_n(4); ctl_clk = 1'b1; ctl_lat = 1'b1;
        wait_n(4); ctl_clk = 1'b0; ctl_lat = 1'b0;
        wait_n(8);
        m_shift = {m_shift[8:0], 1'b1}; m_cnt++;
        model_latch();
        chk_all("R10");
        chk("R10", "right", gain_r, 8'hCD);

        // random words, R2 R8 R9 against model
        for (int k = 0; k < 40; k++) begin
            int n;
            logic [15:0] w;
            n = 6 + int'($urandom_range(7));
            w = 16'($urandom);
            send_word(w, n);
            latch();
            chk_all("R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule